// File: doc/BRIEF.md
# Tagged Next-Address Predictor

This block sits beside the fetch stage and predicts the address to fetch next from the current fetch address alone, before the instruction has been decoded. It holds a direct-mapped table of entries. Each entry carries a valid flag, the complete address of the control instruction it describes as a tag, the taken-path target, and a 2-bit saturating direction counter. A lookup that finds a valid entry whose tag equals the whole fetch address is a hit. On a hit whose counter leans taken, the block returns the stored target. In every other case it returns the fetch address plus four. Instructions that are not control transfers are never written into the table, so they always miss and fall through sequentially.

The execute stage trains the table through a separate port. For each resolved instruction it supplies the instruction's address, the taken-path target, the outcome, whether it is a control transfer, and whether fetch had mispredicted it. A misprediction rewrites the indexed entry. A correct prediction that hit only steps the counter. The lookup is combinational. Training is written at the next rising clock edge. An active-low asynchronous reset invalidates every entry.

Top module: `nap_predictor`

## Requirements
- R1: A lookup that misses returns `lk_pc_i + 4` with `lk_hit_o` low. A lookup misses when the indexed entry is invalid or its tag differs from the full lookup address.
- R2: A lookup that hits returns the stored target when the entry's counter is 2 or 3, and `lk_pc_i + 4` when the counter is 0 or 1. `lk_hit_o` is high in both cases.
- R3: The entry index is address bits [IDX_W+1:2]. Two addresses that share those bits share one entry, and allocating one evicts the other.
- R4: Reset, whether asserted at start-up or in mid-run, invalidates every entry, so that all later lookups miss until the table is trained again.
- R5: A training beat with `tr_valid_i` low, or with `tr_ctrl_i` low (a non-control instruction), changes no entry.
- R6: A valid control beat with `tr_mispred_i` high writes the indexed entry as follows: valid set, tag = `tr_pc_i`, target = `tr_target_i`, counter = 2 when taken and 1 when not taken.
- R7: A valid control beat with `tr_mispred_i` low, whose address hits, keeps the tag and target. It raises the counter on taken and lowers it on not-taken, saturating at 3 and at 0.
- R8: A valid control beat with `tr_mispred_i` low, whose address misses, changes no entry.
- R9: Training takes effect at the next rising edge. A lookup in the same cycle, even at the same index, sees the table as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_pc_i | input | ADDR_W | Fetch address to look up |
| lk_npc_o | output | ADDR_W | Predicted next fetch address |
| lk_hit_o | output | 1 | Lookup found a valid entry with a matching tag |
| tr_valid_i | input | 1 | Training beat present |
| tr_ctrl_i | input | 1 | Resolved instruction is a branch or jump |
| tr_pc_i | input | ADDR_W | Address of the resolved instruction |
| tr_target_i | input | ADDR_W | Taken-path target of the resolved instruction |
| tr_taken_i | input | 1 | Resolved outcome was taken |
| tr_mispred_i | input | 1 | Fetch mispredicted this instruction |

## Verification
Lookup and training can fall in the same cycle, and they can hit the same entry. The bench provokes this by training an address while it looks up that same address, as well as an address that aliases to it. It expects the pre-edge contents in that cycle and the new contents in the cycle after. A reference model in the bench holds the table state. It applies each training beat only after comparing that cycle's lookup, both in directed sequences (counter saturation at both ends, eviction on alias, ignored non-control beats) and in a long random mix with colliding addresses.

// File: rtl/nap_pkg.sv
package nap_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MAX = 2'd3;
  localparam ctr_t CTR_MIN = 2'd0;

  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    if (taken) return (c == CTR_MAX) ? CTR_MAX : c + 2'd1;
    else       return (c == CTR_MIN) ? CTR_MIN : c - 2'd1;
  endfunction

  function automatic ctr_t ctr_seed(input logic taken);
    return taken ? 2'd2 : 2'd1;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/nap_store.sv
module nap_store
  import nap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  ra_idx_i,
  output logic              ra_valid_o,
  output logic [ADDR_W-1:0] ra_tag_o,
  output logic [ADDR_W-1:0] ra_tgt_o,
  output ctr_t              ra_ctr_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  output logic              rb_valid_o,
  output logic [ADDR_W-1:0] rb_tag_o,
  output ctr_t              rb_ctr_o,
  input  logic              we_i,
  input  logic              alloc_i,
  input  logic [IDX_W-1:0]  w_idx_i,
  input  logic [ADDR_W-1:0] w_tag_i,
  input  logic [ADDR_W-1:0] w_tgt_i,
  input  ctr_t              w_ctr_i
);
  localparam int NENT = 1 << IDX_W;

  logic [NENT-1:0]   valid_q;
  logic [ADDR_W-1:0] tag_q [NENT];
  logic [ADDR_W-1:0] tgt_q [NENT];
  ctr_t              ctr_q [NENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             valid_q <= '0;
    else if (we_i && alloc_i) valid_q[w_idx_i] <= 1'b1;
  end

  // payload needs no reset: gated by valid
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      if (alloc_i) begin
        tag_q[w_idx_i] <= w_tag_i;
        tgt_q[w_idx_i] <= w_tgt_i;
      end
      ctr_q[w_idx_i] <= w_ctr_i;
    end
  end

  assign ra_valid_o = valid_q[ra_idx_i];
  assign ra_tag_o   = tag_q[ra_idx_i];
  assign ra_tgt_o   = tgt_q[ra_idx_i];
  assign ra_ctr_o   = ctr_q[ra_idx_i];
  assign rb_valid_o = valid_q[rb_idx_i];
  assign rb_tag_o   = tag_q[rb_idx_i];
  assign rb_ctr_o   = ctr_q[rb_idx_i];

  // R4: table is empty on the first edge after reset release
  a_r4_empty_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> valid_q == '0);

  // R6: an allocation lands valid with its tag
  a_r6_alloc_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && alloc_i) |=> valid_q[$past(w_idx_i)] && (tag_q[$past(w_idx_i)] == $past(w_tag_i)));
endmodule

// File: rtl/nap_lookup.sv
module nap_lookup
  import nap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              e_valid_i,
  input  logic [ADDR_W-1:0] e_tag_i,
  input  logic [ADDR_W-1:0] e_tgt_i,
  input  ctr_t              e_ctr_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] npc_o
);
  logic [ADDR_W-1:0] seq_pc;

  assign seq_pc = pc_i + ADDR_W'(4);
  assign hit_o  = e_valid_i && (e_tag_i == pc_i);
  assign npc_o  = (hit_o && ctr_says_taken(e_ctr_i)) ? e_tgt_i : seq_pc;
endmodule

// File: rtl/nap_train.sv
module nap_train
  import nap_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              ctrl_i,
  input  logic              mispred_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              e_valid_i,
  input  logic [ADDR_W-1:0] e_tag_i,
  input  ctr_t              e_ctr_i,
  output logic              we_o,
  output logic              alloc_o,
  output ctr_t              ctr_o
);
  logic beat, hit;

  assign beat    = valid_i && ctrl_i;
  assign hit     = e_valid_i && (e_tag_i == pc_i);
  assign alloc_o = beat && mispred_i;
  assign we_o    = alloc_o || (beat && hit);
  assign ctr_o   = alloc_o ? ctr_seed(taken_i) : ctr_step(e_ctr_i, taken_i);

  // R7: counter holds at the top on further taken outcomes
  a_r7_sat_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !alloc_o && taken_i && e_ctr_i == 2'd3) |-> ctr_o == 2'd3);

  // R7: counter holds at the bottom on further not-taken outcomes
  a_r7_sat_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !alloc_o && !taken_i && e_ctr_i == 2'd0) |-> ctr_o == 2'd0);

  // R8: correct prediction on a missing entry writes nothing
  a_r8_no_write_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mispred_i && !hit) |-> !we_o);
endmodule

// File: rtl/nap_predictor.sv
module nap_predictor
  import nap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_pc_i,
  output logic [ADDR_W-1:0] lk_npc_o,
  output logic              lk_hit_o,
  input  logic              tr_valid_i,
  input  logic              tr_ctrl_i,
  input  logic [ADDR_W-1:0] tr_pc_i,
  input  logic [ADDR_W-1:0] tr_target_i,
  input  logic              tr_taken_i,
  input  logic              tr_mispred_i
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [IDX_W-1:0]  lk_idx, tr_idx;
  logic              ra_valid, rb_valid, we, alloc;
  logic [ADDR_W-1:0] ra_tag, ra_tgt, rb_tag;
  ctr_t              ra_ctr, rb_ctr, w_ctr;

  assign lk_idx = lk_pc_i[IDX_HI:IDX_LO];
  assign tr_idx = tr_pc_i[IDX_HI:IDX_LO];

  nap_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ra_idx_i   (lk_idx),
    .ra_valid_o (ra_valid),
    .ra_tag_o   (ra_tag),
    .ra_tgt_o   (ra_tgt),
    .ra_ctr_o   (ra_ctr),
    .rb_idx_i   (tr_idx),
    .rb_valid_o (rb_valid),
    .rb_tag_o   (rb_tag),
    .rb_ctr_o   (rb_ctr),
    .we_i       (we),
    .alloc_i    (alloc),
    .w_idx_i    (tr_idx),
    .w_tag_i    (tr_pc_i),
    .w_tgt_i    (tr_target_i),
    .w_ctr_i    (w_ctr)
  );

  nap_lookup #(.ADDR_W(ADDR_W)) u_lookup (
    .pc_i      (lk_pc_i),
    .e_valid_i (ra_valid),
    .e_tag_i   (ra_tag),
    .e_tgt_i   (ra_tgt),
    .e_ctr_i   (ra_ctr),
    .hit_o     (lk_hit_o),
    .npc_o     (lk_npc_o)
  );

  nap_train #(.ADDR_W(ADDR_W)) u_train (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (tr_valid_i),
    .ctrl_i    (tr_ctrl_i),
    .mispred_i (tr_mispred_i),
    .taken_i   (tr_taken_i),
    .pc_i      (tr_pc_i),
    .e_valid_i (rb_valid),
    .e_tag_i   (rb_tag),
    .e_ctr_i   (rb_ctr),
    .we_o      (we),
    .alloc_o   (alloc),
    .ctr_o     (w_ctr)
  );

  // R1: a miss always falls through sequentially
  a_r1_miss_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_hit_o |-> lk_npc_o == lk_pc_i + ADDR_W'(4));

  // R5: non-control or idle beats never write
  a_r5_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tr_valid_i && tr_ctrl_i) |-> !we);
endmodule

// File: tb/nap_predictor_bench.sv
`timescale 1ns/1ps
module nap_predictor_bench;
  localparam int AW = 32;
  localparam int IW = 6;
  localparam int NE = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] lk_pc = '0;
  logic [AW-1:0] lk_npc;
  logic          lk_hit;
  logic          tr_valid = 1'b0, tr_ctrl = 1'b0, tr_taken = 1'b0, tr_mispred = 1'b0;
  logic [AW-1:0] tr_pc = '0, tr_target = '0;

  int n_run = 0;
  int n_fail = 0;

  bit            m_v   [NE];
  logic [AW-1:0] m_tag [NE];
  logic [AW-1:0] m_tgt [NE];
  int            m_c   [NE];

  always #2 clk = ~clk;

  nap_predictor #(.ADDR_W(AW), .IDX_W(IW)) u_nap_predictor (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .lk_pc_i      (lk_pc),
    .lk_npc_o     (lk_npc),
    .lk_hit_o     (lk_hit),
    .tr_valid_i   (tr_valid),
    .tr_ctrl_i    (tr_ctrl),
    .tr_pc_i      (tr_pc),
    .tr_target_i  (tr_target),
    .tr_taken_i   (tr_taken),
    .tr_mispred_i (tr_mispred)
  );

  function automatic int idx_of(input logic [AW-1:0] pc);
    return int'((pc >> 2) % NE);
  endfunction

  function automatic bit m_hit(input logic [AW-1:0] pc);
    return m_v[idx_of(pc)] && (m_tag[idx_of(pc)] == pc);
  endfunction

  function automatic logic [AW-1:0] m_npc(input logic [AW-1:0] pc);
    if (m_hit(pc) && m_c[idx_of(pc)] >= 2) return m_tgt[idx_of(pc)];
    return pc + 4;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < NE; i++) m_v[i] = 1'b0;
  endtask

  task automatic m_train();
    int i;
    if (!(tr_valid && tr_ctrl)) return;
    i = idx_of(tr_pc);
    if (tr_mispred) begin
      m_v[i] = 1'b1; m_tag[i] = tr_pc; m_tgt[i] = tr_target; m_c[i] = tr_taken ? 2 : 1;
    end else if (m_hit(tr_pc)) begin
      if (tr_taken) m_c[i] = (m_c[i] == 3) ? 3 : m_c[i] + 1;
      else          m_c[i] = (m_c[i] == 0) ? 0 : m_c[i] - 1;
    end
  endtask

  task automatic compare(input string rq);
    bit eh;
    logic [AW-1:0] en;
    string tag;
    eh = m_hit(lk_pc);
    en = m_npc(lk_pc);
    tag = (rq != "") ? rq : (eh ? "R2" : "R1");
    n_run++;
    if (lk_hit !== eh || lk_npc !== en) begin
      n_fail++;
      $display("FAIL %s pc=%h: hit=%0b npc=%h expected hit=%0b npc=%h",
               tag, lk_pc, lk_hit, lk_npc, eh, en);
    end
  endtask

  // one clock: drive, compare against pre-edge model, then advance model
  task automatic step(input logic [AW-1:0] lpc, input bit tv, input bit tc,
                      input logic [AW-1:0] tpc, input logic [AW-1:0] ttgt,
                      input bit tk, input bit tm, input string rq);
    @(negedge clk);
    lk_pc = lpc; tr_valid = tv; tr_ctrl = tc; tr_pc = tpc;
    tr_target = ttgt; tr_taken = tk; tr_mispred = tm;
    #1;
    compare(rq);
    @(posedge clk);
    m_train();
  endtask

  task automatic look(input logic [AW-1:0] lpc, input string rq);
    step(lpc, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, rq);
  endtask

  localparam logic [AW-1:0] PA = 32'h0000_1000;
  localparam logic [AW-1:0] PB = 32'h0000_1010;
  localparam logic [AW-1:0] PC = 32'h0000_1020;
  localparam logic [AW-1:0] PD = PA + 4 * NE;
  localparam logic [AW-1:0] TA = 32'h0000_8000;
  localparam logic [AW-1:0] TB = 32'h0000_8400;
  localparam logic [AW-1:0] TD = 32'h0000_8800;

  initial begin
    m_clear();
    #9;
    // R4: reset state, every lookup misses
    @(negedge clk); lk_pc = PA; #1; compare("R4");
    rst_ni = 1'b1;
    look(PA, "R4"); look(PB, "R4"); look(PD, "R1");

    // R5: ignored beats
    step(PA, 1'b1, 1'b0, PA, TA, 1'b1, 1'b1, "R5");
    look(PA, "R5");
    step(PA, 1'b0, 1'b1, PA, TA, 1'b1, 1'b1, "R5");
    look(PA, "R5");

    // R6 + R9: allocate while looking up the same address
    step(PA, 1'b1, 1'b1, PA, TA, 1'b1, 1'b1, "R9");
    look(PA, "R6");

    // R7: walk the counter down and back up, with saturation
    step(PA, 1'b1, 1'b1, PA, TA, 1'b0, 1'b0, "R7");
    look(PA, "R7");
    step(PA, 1'b1, 1'b1, PA, TA, 1'b0, 1'b0, "R7");
    step(PA, 1'b1, 1'b1, PA, TA, 1'b0, 1'b0, "R7");
    step(PA, 1'b1, 1'b1, PA, TA, 1'b1, 1'b0, "R7");
    look(PA, "R7");
    step(PA, 1'b1, 1'b1, PA, TA, 1'b1, 1'b0, "R7");
    look(PA, "R7");
    step(PA, 1'b1, 1'b1, PA, TA, 1'b1, 1'b0, "R7");
    step(PA, 1'b1, 1'b1, PA, TA, 1'b1, 1'b0, "R7");
    step(PA, 1'b1, 1'b1, PA, TA, 1'b0, 1'b0, "R7");
    look(PA, "R7");

    // R6: not-taken allocation seeds weak not-taken
    step(PB, 1'b1, 1'b1, PB, TB, 1'b0, 1'b1, "R6");
    look(PB, "R6");
    step(PB, 1'b1, 1'b1, PB, TB, 1'b1, 1'b0, "R7");
    look(PB, "R7");

    // R8: correct beat on an absent entry
    step(PC, 1'b1, 1'b1, PC, TD, 1'b1, 1'b0, "R8");
    look(PC, "R8");

    // R3: alias shares an index and evicts
    look(PD, "R3");
    step(PA, 1'b1, 1'b1, PD, TD, 1'b1, 1'b1, "R3");
    look(PA, "R3");
    look(PD, "R3");

    // random mix with colliding addresses
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] lp, tp, tt, act;
      bit tk, tc;
      lp = 32'h1000 + ($urandom % 96) * 4;
      tp = 32'h1000 + ($urandom % 96) * 4;
      tt = 32'h8000 + ($urandom % 32) * 4;
      tk = $urandom % 2;
      tc = ($urandom % 4) != 0;
      act = tk ? tt : tp + 4;
      step(lp, ($urandom % 8) != 0, tc, tp, tt, tk, m_npc(tp) != act, "");
    end

    // R4: reset in mid-run clears all entries
    @(negedge clk); rst_ni = 1'b0; tr_valid = 1'b0; m_clear();
    lk_pc = PB; #1; compare("R4");
    @(negedge clk); rst_ni = 1'b1;
    for (int k = 0; k < 8; k++) look(32'h1000 + k * 4, "R4");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule